// File: doc/BRIEF.md
# Shared Address/Data Port Controller

This block runs two 8-bit bidirectional pin groups. Each group can act as general-purpose I/O, or it can carry the multiplexed address/data bus during an external-memory access. In I/O mode, every pin drives the bit held in its port's output data register. Software picks the drive style for each port: push-pull (both drivers active) or open-drain (only the low driver is used, so a 1 leaves the pin released and an external pull-up sets its level). The pin-input registers always return the live pin levels.

A memory controller takes over the pins by asserting an ownership request. It supplies a 16-bit address/data value and a direction flag: drive the value out, or release the pins so it can capture read data. The request is registered, so any change of owner reaches the pads one clock later and never glitches them. A bus access does not alter the user data registers. When ownership is released, the pins go back to the register contents. While reset is held, every driver is off and the pins are only marked as weakly pulled high.

The register bus is a 3-bit address with a single-cycle write strobe and a combinational read. The address map is:
- 0: driver-mode byte.
- 1: low-port output data.
- 2: high-port output data.
- 3: low-port pin input.
- 4: high-port pin input.
- Other addresses read as zero.

Top module: `adport_ctrl`

## Requirements
- R1: While `rst` is high, `pad_oe_o` is all zeros and `pad_pu_o` is all ones. After reset, both data registers read 8'hFF and the driver-mode byte reads 8'h00.
- R2: In I/O mode with a port set to push-pull, all 8 of that port's `pad_oe_o` bits are 1 and its `pad_do_o` equals its data register.
- R3: In I/O mode with a port set to open-drain, a data bit of 0 gives oe=1 and do=0, and a data bit of 1 gives oe=0, so the pin reads high.
- R4: In the driver-mode byte, bit 7 selects the mode of the low port (pins 7:0) and bit 6 selects the mode of the high port (pins 15:8). A 1 selects push-pull and a 0 selects open-drain. The other bits read as 0.
- R5: Address 3 returns `pins_i[7:0]` and address 4 returns `pins_i[15:8]`, whatever the mode or owner.
- R6: One cycle after `ext_own_i`=1 is sampled, the pads follow the bus. If `ext_drive_i`=1, all pads are push-pull with `pad_do_o` equal to the sampled `ext_dout_i`, whatever the driver-mode byte says. If `ext_drive_i`=0, all pads are released. `ext_din_o` always equals `pins_i`.
- R7: One cycle after `ext_own_i` is sampled low again, the pads once more reflect the data registers and the driver-mode byte, and those registers are unchanged by the access.
- R8: A change of `ext_own_i` has no effect on the pads until the next rising clock edge.
- R9: A write to a data address updates that register on the next edge. Writes to the pin-input addresses are ignored.
- R10: A data-register write during bus ownership is stored, but it does not reach the pads until I/O mode returns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; also gates all drivers off |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register address |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data (combinational) |
| ext_own_i | input | 1 | External-memory access owns the pins |
| ext_drive_i | input | 1 | During ownership: 1 drives address/data, 0 releases pins |
| ext_dout_i | input | 16 | Address/data value to drive |
| ext_din_o | output | 16 | Pin levels returned to the memory controller |
| pins_i | input | 16 | Live pin levels |
| pad_oe_o | output | 16 | Per-pin output enable |
| pad_do_o | output | 16 | Per-pin output value |
| pad_pu_o | output | 16 | Weak pull-up active (reset state) |

## Verification
The assertions check the following on every cycle: drivers are off during reset, the open-drain rule never drives a high level, push-pull ports in I/O mode follow their data registers, the bus drive and release outcomes one cycle after a sampled request, and data-register writes landing on the next edge. Some behaviour only the bench scenarios can show. These are the exact cycle at which an owner change reaches the pads, the restoration of untouched user data after an access, that writes to pin-input addresses are ignored, and the bit positions of the driver-mode byte. They also cover readback of levels driven from outside while the pads are released.

// File: rtl/adport_pkg.sv
package adport_pkg;

    typedef enum logic { DRV_OPEN_DRAIN = 1'b0, DRV_PUSH_PULL = 1'b1 } drv_kind_e;
    typedef enum logic { OWN_IO = 1'b0, OWN_BUS = 1'b1 } pad_owner_e;

    typedef struct packed {
        logic oe;
        logic dout;
    } pad_bit_t;

    typedef struct packed {
        pad_owner_e owner;
        logic       drive;
    } bus_ctl_t;

    localparam int unsigned CFG_ADDR = 0;

    function automatic int unsigned data_addr(input int unsigned port);
        return 1 + port;
    endfunction

    function automatic int unsigned pin_addr(input int unsigned port, input int unsigned nports);
        return 1 + nports + port;
    endfunction

    // Per-pin driver choice from owner, drive style and the two data sources.
    function automatic pad_bit_t drive_bit(input pad_owner_e owner, input drv_kind_e kind,
                                           input logic bus_drive, input logic bus_bit,
                                           input logic user_bit);
        pad_bit_t r;
        if (owner == OWN_BUS) begin
            r.oe   = bus_drive;
            r.dout = bus_bit;
        end else if (kind == DRV_PUSH_PULL) begin
            r.oe   = 1'b1;
            r.dout = user_bit;
        end else begin
            r.oe   = ~user_bit;
            r.dout = 1'b0;
        end
        return r;
    endfunction

endpackage

// File: rtl/adport_regs.sv
module adport_regs
    import adport_pkg::*;
#(
    parameter int PORT_W    = 8,
    parameter int NUM_PORTS = 2,
    parameter int ADDR_W    = 3,
    localparam int BUS_W    = PORT_W * NUM_PORTS
) (
    input  logic                              clk,
    input  logic                              rst,
    input  logic                              wr_i,
    input  logic [ADDR_W-1:0]                 addr_i,
    input  logic [PORT_W-1:0]                 wdata_i,
    input  logic [BUS_W-1:0]                  pins_i,
    output logic [PORT_W-1:0]                 rdata_o,
    output logic [NUM_PORTS-1:0][PORT_W-1:0]  data_q,
    output logic [PORT_W-1:0]                 cfg_q
);
    // Only the top NUM_PORTS bits of the mode byte exist.
    localparam logic [PORT_W-1:0] CFG_MASK = ~({PORT_W{1'b1}} >> NUM_PORTS);

    always_ff @(posedge clk) begin
        if (rst) begin
            data_q <= '1;
            cfg_q  <= '0;
        end else if (wr_i) begin
            if (addr_i == ADDR_W'(CFG_ADDR))
                cfg_q <= wdata_i & CFG_MASK;
            for (int p = 0; p < NUM_PORTS; p++) begin
                if (addr_i == ADDR_W'(data_addr(p)))
                    data_q[p] <= wdata_i;
            end
        end
    end

    always_comb begin
        rdata_o = '0;
        if (addr_i == ADDR_W'(CFG_ADDR))
            rdata_o = cfg_q;
        for (int p = 0; p < NUM_PORTS; p++) begin
            if (addr_i == ADDR_W'(data_addr(p)))
                rdata_o = data_q[p];
            if (addr_i == ADDR_W'(pin_addr(p, NUM_PORTS)))
                rdata_o = pins_i[p*PORT_W +: PORT_W];
        end
    end

endmodule

// File: rtl/adport_owner_reg.sv
module adport_owner_reg
    import adport_pkg::*;
#(
    parameter int BUS_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             own_i,
    input  logic             drive_i,
    input  logic [BUS_W-1:0] val_i,
    output bus_ctl_t         ctl_q,
    output logic [BUS_W-1:0] val_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q <= '{owner: OWN_IO, drive: 1'b0};
            val_q <= '0;
        end else begin
            ctl_q <= '{owner: own_i ? OWN_BUS : OWN_IO, drive: drive_i};
            val_q <= val_i;
        end
    end
endmodule

// File: rtl/adport_pad_mux.sv
module adport_pad_mux
    import adport_pkg::*;
#(
    parameter int PORT_W = 8
) (
    input  logic              rst,
    input  bus_ctl_t          ctl,
    input  logic [PORT_W-1:0] bus_val,
    input  logic              push_pull,
    input  logic [PORT_W-1:0] user_val,
    output logic [PORT_W-1:0] oe_o,
    output logic [PORT_W-1:0] do_o
);
    drv_kind_e kind;
    assign kind = push_pull ? DRV_PUSH_PULL : DRV_OPEN_DRAIN;

    for (genvar b = 0; b < PORT_W; b++) begin : g_bit
        pad_bit_t pb;
        always_comb begin
            pb = drive_bit(ctl.owner, kind, ctl.drive, bus_val[b], user_val[b]);
            if (rst) pb = '{oe: 1'b0, dout: 1'b0};
        end
        assign oe_o[b] = pb.oe;
        assign do_o[b] = pb.dout;
    end
endmodule

// File: rtl/adport_ctrl.sv
module adport_ctrl
    import adport_pkg::*;
#(
    parameter int PORT_W    = 8,
    parameter int NUM_PORTS = 2,
    parameter int ADDR_W    = 3,
    localparam int BUS_W    = PORT_W * NUM_PORTS
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr_i,
    input  logic [ADDR_W-1:0] reg_addr_i,
    input  logic [PORT_W-1:0] reg_wdata_i,
    output logic [PORT_W-1:0] reg_rdata_o,
    input  logic              ext_own_i,
    input  logic              ext_drive_i,
    input  logic [BUS_W-1:0]  ext_dout_i,
    output logic [BUS_W-1:0]  ext_din_o,
    input  logic [BUS_W-1:0]  pins_i,
    output logic [BUS_W-1:0]  pad_oe_o,
    output logic [BUS_W-1:0]  pad_do_o,
    output logic [BUS_W-1:0]  pad_pu_o
);
    logic [NUM_PORTS-1:0][PORT_W-1:0] data_q;
    logic [PORT_W-1:0]                cfg_q;
    bus_ctl_t                         ctl_q;
    logic [BUS_W-1:0]                 bus_val_q;
    logic                             own_q;

    adport_regs #(.PORT_W(PORT_W), .NUM_PORTS(NUM_PORTS), .ADDR_W(ADDR_W)) regs_i (
        .clk(clk), .rst(rst), .wr_i(reg_wr_i), .addr_i(reg_addr_i),
        .wdata_i(reg_wdata_i), .pins_i(pins_i), .rdata_o(reg_rdata_o),
        .data_q(data_q), .cfg_q(cfg_q)
    );

    adport_owner_reg #(.BUS_W(BUS_W)) owner_i (
        .clk(clk), .rst(rst), .own_i(ext_own_i), .drive_i(ext_drive_i),
        .val_i(ext_dout_i), .ctl_q(ctl_q), .val_q(bus_val_q)
    );

    assign own_q = (ctl_q.owner == OWN_BUS);

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        adport_pad_mux #(.PORT_W(PORT_W)) mux_i (
            .rst(rst), .ctl(ctl_q),
            .bus_val(bus_val_q[p*PORT_W +: PORT_W]),
            .push_pull(cfg_q[PORT_W-1-p]),
            .user_val(data_q[p]),
            .oe_o(pad_oe_o[p*PORT_W +: PORT_W]),
            .do_o(pad_do_o[p*PORT_W +: PORT_W])
        );
    end

    assign ext_din_o = pins_i;
    assign pad_pu_o  = {BUS_W{rst}};

endmodule

// File: rtl/adport_ctrl_chk.sv
module adport_ctrl_chk #(
    parameter int PORT_W    = 8,
    parameter int NUM_PORTS = 2,
    parameter int ADDR_W    = 3,
    localparam int BUS_W    = PORT_W * NUM_PORTS
) (
    input logic                             clk,
    input logic                             rst,
    input logic                             reg_wr_i,
    input logic [ADDR_W-1:0]                reg_addr_i,
    input logic [PORT_W-1:0]                reg_wdata_i,
    input logic                             ext_own_i,
    input logic                             ext_drive_i,
    input logic [BUS_W-1:0]                 ext_dout_i,
    input logic [BUS_W-1:0]                 pad_oe_o,
    input logic [BUS_W-1:0]                 pad_do_o,
    input logic [BUS_W-1:0]                 pad_pu_o,
    input logic                             own_q,
    input logic [PORT_W-1:0]                cfg_q,
    input logic [NUM_PORTS-1:0][PORT_W-1:0] data_q
);
    // R1
    always @(posedge clk) begin
        if (rst) begin
            reset_off_chk: assert (pad_oe_o == '0 && pad_pu_o == '1);
        end
    end

    // R6
    bus_drive_chk: assert property (@(posedge clk) disable iff (rst)
        (ext_own_i && ext_drive_i) |=> (pad_oe_o == '1 && pad_do_o == $past(ext_dout_i)));

    // R6
    bus_release_chk: assert property (@(posedge clk) disable iff (rst)
        (ext_own_i && !ext_drive_i) |=> (pad_oe_o == '0));

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_chk
        // R3
        open_drain_chk: assert property (@(posedge clk) disable iff (rst)
            (!own_q && !cfg_q[PORT_W-1-p]) |->
                ((pad_oe_o[p*PORT_W +: PORT_W] & pad_do_o[p*PORT_W +: PORT_W]) == '0));

        // R2 (also R7: user data shown again in I/O mode)
        io_push_pull_chk: assert property (@(posedge clk) disable iff (rst)
            (!own_q && cfg_q[PORT_W-1-p]) |->
                (pad_oe_o[p*PORT_W +: PORT_W] == '1 && pad_do_o[p*PORT_W +: PORT_W] == data_q[p]));

        // R9
        data_write_chk: assert property (@(posedge clk) disable iff (rst)
            (reg_wr_i && reg_addr_i == ADDR_W'(1 + p)) |=> (data_q[p] == $past(reg_wdata_i)));
    end
endmodule

bind adport_ctrl adport_ctrl_chk #(.PORT_W(PORT_W), .NUM_PORTS(NUM_PORTS), .ADDR_W(ADDR_W)) chk_i (
    .clk(clk), .rst(rst), .reg_wr_i(reg_wr_i), .reg_addr_i(reg_addr_i),
    .reg_wdata_i(reg_wdata_i), .ext_own_i(ext_own_i), .ext_drive_i(ext_drive_i),
    .ext_dout_i(ext_dout_i), .pad_oe_o(pad_oe_o), .pad_do_o(pad_do_o),
    .pad_pu_o(pad_pu_o), .own_q(own_q), .cfg_q(cfg_q), .data_q(data_q)
);

// File: tb/adport_ctrl_tb.sv
module adport_ctrl_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [7:0]  reg_wdata = '0;
    logic [7:0]  reg_rdata;
    logic        ext_own = 1'b0;
    logic        ext_drive = 1'b0;
    logic [15:0] ext_dout = '0;
    logic [15:0] ext_din;
    logic [15:0] pins;
    logic [15:0] pad_oe, pad_do, pad_pu;
    logic [15:0] tb_en = '0;
    logic [15:0] tb_val = '0;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    // Board model: driven pad, else outside driver, else pull-up.
    assign pins = (pad_oe & pad_do) | (~pad_oe & ((tb_en & tb_val) | ~tb_en));

    adport_ctrl dut_i (
        .clk(clk), .rst(rst), .reg_wr_i(reg_wr), .reg_addr_i(reg_addr),
        .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata), .ext_own_i(ext_own),
        .ext_drive_i(ext_drive), .ext_dout_i(ext_dout), .ext_din_o(ext_din),
        .pins_i(pins), .pad_oe_o(pad_oe), .pad_do_o(pad_do), .pad_pu_o(pad_pu)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    // Expected I/O-mode pad state from the requirement rules (R2, R3, R4).
    function automatic logic [31:0] exp_io(input logic [7:0] cfg, input logic [7:0] lo, input logic [7:0] hi);
        logic [7:0] oel, dol, oeh, doh;
        if (cfg[7]) begin oel = 8'hFF; dol = lo; end else begin oel = ~lo; dol = 8'h00; end
        if (cfg[6]) begin oeh = 8'hFF; doh = hi; end else begin oeh = ~hi; doh = 8'h00; end
        return {oeh, oel, doh, dol};
    endfunction

    task automatic t_reset();
        logic [7:0] d;
        @(negedge clk);
        chk("R1 oe in reset", pad_oe, 16'h0000);
        chk("R1 pullup in reset", pad_pu, 16'hFFFF);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 pullup released", pad_pu, 16'h0000);
        rd(3'd1, d); chk("R1 low data reset", d, 8'hFF);
        rd(3'd2, d); chk("R1 high data reset", d, 8'hFF);
        rd(3'd0, d); chk("R1 mode reset", d, 8'h00);
        chk("R3 od data FF undriven", pad_oe, 16'h0000);
        rd(3'd3, d); chk("R3 od reads high", d, 8'hFF);
    endtask

    task automatic t_open_drain();
        logic [7:0] d;
        wr(3'd1, 8'h5A);
        chk("R3 od pads", {pad_oe, pad_do}, exp_io(8'h00, 8'h5A, 8'hFF));
        rd(3'd3, d); chk("R5 od low pins", d, 8'h5A);
    endtask

    task automatic t_mode_bits();
        logic [7:0] d;
        wr(3'd2, 8'hC3);
        wr(3'd0, 8'hFF);
        rd(3'd0, d); chk("R4 unused mode bits zero", d, 8'hC0);
        wr(3'd0, 8'h80);
        chk("R4 bit7 low push-pull", {pad_oe, pad_do}, exp_io(8'h80, 8'h5A, 8'hC3));
        chk("R2 push-pull low value", pad_do[7:0], 8'h5A);
        wr(3'd0, 8'h40);
        chk("R4 bit6 high push-pull", {pad_oe, pad_do}, exp_io(8'h40, 8'h5A, 8'hC3));
        chk("R2 push-pull high oe", pad_oe[15:8], 8'hFF);
    endtask

    task automatic t_pin_read();
        logic [7:0] d;
        wr(3'd0, 8'h00);
        wr(3'd2, 8'hFF);
        tb_en = 16'hFF00; tb_val = 16'h3C00;
        rd(3'd4, d); chk("R5 high pins external level", d, 8'h3C);
        tb_en = '0;
        wr(3'd3, 8'h00);
        rd(3'd1, d); chk("R9 pin-addr write ignored", d, 8'h5A);
        chk("R9 pads unchanged", {pad_oe, pad_do}, exp_io(8'h00, 8'h5A, 8'hFF));
        wr(3'd2, 8'hC3);
        rd(3'd2, d); chk("R9 data write", d, 8'hC3);
    endtask

    task automatic t_bus_cycle();
        logic [7:0] d;
        wr(3'd0, 8'h00);
        @(negedge clk);
        ext_own = 1'b1; ext_drive = 1'b1; ext_dout = 16'h1234;
        #1;
        chk("R8 no change before edge", {pad_oe, pad_do}, exp_io(8'h00, 8'h5A, 8'hC3));
        @(negedge clk);
        chk("R6 bus push-pull oe", pad_oe, 16'hFFFF);
        chk("R6 bus value", pad_do, 16'h1234);
        wr(3'd1, 8'h11);
        chk("R10 write hidden in bus mode", pad_do, 16'h1234);
        ext_drive = 1'b0;
        tb_en = 16'hFFFF; tb_val = 16'hBEEF;
        @(negedge clk);
        chk("R6 bus release", pad_oe, 16'h0000);
        chk("R6 read data to bus", ext_din, 16'hBEEF);
        tb_en = '0;
        ext_own = 1'b0;
        #1;
        chk("R8 still bus before edge", pad_oe, 16'h0000);
        @(negedge clk);
        chk("R7 user data restored", {pad_oe, pad_do}, exp_io(8'h00, 8'h11, 8'hC3));
        rd(3'd2, d); chk("R7 high data untouched", d, 8'hC3);
        wr(3'd0, 8'hC0);
        chk("R7 push-pull after access", pad_do, 16'hC311);
    endtask

    initial begin
        repeat (2) @(negedge clk);
        t_reset();
        t_open_drain();
        t_mode_bits();
        t_pin_read();
        t_bus_cycle();
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule